// File: doc/BRIEF.md
# GPIO Port with Level-Sensitive Interrupt Merge

This block is a register-mapped general-purpose I/O unit. It has two parts. The first is a four-bit bidirectional port with a direction control for each bit and a data latch. The second is a sixteen-input interrupt front end. Each interrupt-capable pin is active-low and level-sensitive. A per-bit enable mask selects which pins count, and the enabled low pins are ORed onto a single registered request line. Software on a simple synchronous read/write strobe bus programs the direction, drives the port, reads the port back, sets the interrupt mask and reads the synchronized interrupt pin levels to find which source is requesting.

The block has two resets. Power-on reset is asynchronous and active-low. It clears the direction and interrupt-enable settings. Manual reset is synchronous and active-low. It quiets the bus and the request line but keeps every setting. The data latch has no reset at all, so it keeps its contents through both resets and through standby. While the standby input is high, the register settings are frozen, but the interrupt logic keeps running so a pin can still raise a request. Every pin is passed through a two-stage synchronizer on the bus clock before any logic uses it.

The register bus has no back-pressure. A read or write strobe is accepted in the cycle it is high. A read answers exactly one cycle later with `bus_rvalid`, and the requester must take that data in that cycle.

Top module: `gpio_lvl_port`

## Requirements
- R1: The direction register is at address 0. The direction for port bit n is held at register bit 2n: 1 selects output and 0 selects input. Odd bit positions and all bits above 2*PORT_W-1 read as 0 and ignore writes. `pad_oe[n]` equals the stored direction bit n one cycle after the write.
- R2: For an output bit, `pad_out[n]` carries the last value written to data register bit n (address 1). A read of that bit returns the written value, whatever the level on the pin.
- R3: For an input bit, a read of the data register returns the pin level after two synchronizer stages. A level presented before clock edge k is visible to a read strobe sampled at edge k+2 or later, and is not visible to a read strobe sampled at edge k+1.
- R4: Data register bits 15 to 4 always read as 0 and ignore writes.
- R5: The data latch is not changed by power-on reset, by manual reset or by standby.
- R6: The interrupt-enable register (address 2, 16 bits, bit i enables pin i) reads as 0 after power-on reset. Manual reset and standby leave it unchanged.
- R7: `irq_req` rises three clock edges after an enabled pin goes low. It stays high for as long as that pin stays low, and it falls three edges after the last enabled low pin returns high. No request is latched.
- R8: A pin whose enable bit is 0 never causes `irq_req`, whatever its level.
- R9: Address 3 returns the 16 synchronized interrupt pin levels, with bit i for pin i. Writes to address 3 are ignored.
- R10: While `mrst_n` is low, `irq_req` and `bus_rvalid` are 0 from the next edge on, and bus writes are ignored.
- R11: While `standby` is high, bus writes change no register, reads are still answered, and the interrupt path keeps working.
- R12: A read strobe at edge k gives `bus_rvalid` high for exactly one cycle after edge k, with the data as it was before edge k. A write to the same address in the same cycle is not seen by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all pin sampling uses it |
| por_n | input | 1 | Power-on reset, asynchronous, active-low |
| mrst_n | input | 1 | Manual reset, synchronous, active-low |
| standby | input | 1 | High while the chip is in standby; freezes register writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register select: 0 direction, 1 data, 2 interrupt enable, 3 pin levels |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | One-cycle read response |
| pad_in | input | 4 | Port pin levels from the pads |
| pad_out | output | 4 | Port output values to the pads |
| pad_oe | output | 4 | Port output enables, 1 drives the pad |
| gpin_n | input | 16 | Active-low interrupt-capable pins |
| irq_req | output | 1 | Merged level interrupt request |

## Verification
Two functions can fall in the same cycle. The first case is a read and a write to the same register: the bench raises both strobes in one cycle on the interrupt-enable register, expects the old mask in the response, and expects the new mask from the following read. The second case is a change to the enable mask while a pin is already being held low: the bench writes the enable bit with the pin low and expects `irq_req` to stay low at the next sample and be high at the one after. Manual reset colliding with a pending request is handled the same way: the request must drop one cycle into the reset and come back after release without the mask being rewritten.

// File: rtl/gpio_lvl_pkg.sv
`timescale 1ns/1ps
package gpio_lvl_pkg;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_PINS = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/gpio_lvl_sync.sv
`timescale 1ns/1ps
module gpio_lvl_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;

  // Stage 0 takes the raw pin; every later stage takes the one before it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_lvl_regs.sv
`timescale 1ns/1ps
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned IRQ_W  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              standby,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [SEL_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [PORT_W-1:0] pin_s,
  input  logic [IRQ_W-1:0]  lvl_s,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] dat_q,
  output logic [IRQ_W-1:0]  ien_q,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);

  localparam int unsigned DIR_SPAN = 2 * PORT_W;

  reg_sel_e   sel;
  logic       wr_ok;
  logic       rd_ok;
  logic [REG_W-1:0] dir_view;
  logic [REG_W-1:0] dat_view;
  logic [REG_W-1:0] ien_view;
  logic [REG_W-1:0] pin_view;
  logic [REG_W-1:0] rd_mux;
  logic [PORT_W-1:0] dir_wr;

  assign sel   = reg_sel_e'(bus_addr);
  // Manual reset blocks the whole bus; standby blocks only the writes.
  assign wr_ok = bus_wr & mrst_n & ~standby;
  assign rd_ok = bus_rd & mrst_n;

  // Direction bits are taken from the even write-data positions.
  for (genvar n = 0; n < PORT_W; n++) begin : g_dir_pick
    assign dir_wr[n] = bus_wdata[2*n];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q <= '0;
    end else if (wr_ok && sel == SEL_DIR) begin
      dir_q <= dir_wr;
    end
  end

  // The data latch has no reset: it survives both resets and standby.
  always_ff @(posedge clk) begin
    if (wr_ok && sel == SEL_DATA) begin
      dat_q <= bus_wdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ien_q <= '0;
    end else if (wr_ok && sel == SEL_IEN) begin
      ien_q <= bus_wdata[IRQ_W-1:0];
    end
  end

  // Read views: direction spread onto even positions, data muxed per bit.
  for (genvar n = 0; n < PORT_W; n++) begin : g_port_view
    assign dir_view[2*n]   = dir_q[n];
    assign dir_view[2*n+1] = 1'b0;
    assign dat_view[n]     = dir_q[n] ? dat_q[n] : pin_s[n];
  end

  if (REG_W > DIR_SPAN) begin : g_dir_pad
    assign dir_view[REG_W-1:DIR_SPAN] = '0;
  end

  if (REG_W > PORT_W) begin : g_dat_pad
    assign dat_view[REG_W-1:PORT_W] = '0;
  end

  if (REG_W > IRQ_W) begin : g_irq_pad
    assign ien_view = {{(REG_W-IRQ_W){1'b0}}, ien_q};
    assign pin_view = {{(REG_W-IRQ_W){1'b0}}, lvl_s};
  end else begin : g_irq_full
    assign ien_view = ien_q;
    assign pin_view = lvl_s;
  end

  always_comb begin
    unique case (sel)
      SEL_DIR:  rd_mux = dir_view;
      SEL_DATA: rd_mux = dat_view;
      SEL_IEN:  rd_mux = ien_view;
      SEL_PINS: rd_mux = pin_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else if (!mrst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_ok;
      if (rd_ok) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpio_lvl_irq.sv
`timescale 1ns/1ps
module gpio_lvl_irq #(
  parameter int unsigned IRQ_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic [IRQ_W-1:0] lvl_s,
  input  logic [IRQ_W-1:0] ien_q,
  output logic             irq_req
);

  logic [IRQ_W-1:0] hit;

  // A source counts only when it is enabled and its synchronized level is low.
  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    assign hit[i] = ien_q[i] & ~lvl_s[i];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      irq_req <= 1'b0;
    end else if (!mrst_n) begin
      irq_req <= 1'b0;
    end else begin
      irq_req <= |hit;
    end
  end

endmodule

// File: rtl/gpio_lvl_port.sv
`timescale 1ns/1ps
module gpio_lvl_port
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned PORT_W  = 4,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned IRQ_W   = 16,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              standby,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  input  logic [IRQ_W-1:0]  gpin_n,
  output logic              irq_req
);

  logic [PORT_W-1:0] pin_s;
  logic [IRQ_W-1:0]  lvl_s;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] dat_q;
  logic [IRQ_W-1:0]  ien_q;

  // Port pins idle at 0; the active-low interrupt pins idle high so that
  // reset does not look like a pending request.
  gpio_lvl_sync #(.W(PORT_W), .STAGES(SYNC_ST), .RST_VAL('0)) u_port_sync (
    .clk   (clk),
    .por_n (por_n),
    .din   (pad_in),
    .dout  (pin_s)
  );

  gpio_lvl_sync #(.W(IRQ_W), .STAGES(SYNC_ST), .RST_VAL('1)) u_irq_sync (
    .clk   (clk),
    .por_n (por_n),
    .din   (gpin_n),
    .dout  (lvl_s)
  );

  gpio_lvl_regs #(.PORT_W(PORT_W), .REG_W(REG_W), .IRQ_W(IRQ_W)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .mrst_n     (mrst_n),
    .standby    (standby),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_s      (pin_s),
    .lvl_s      (lvl_s),
    .dir_q      (dir_q),
    .dat_q      (dat_q),
    .ien_q      (ien_q),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  gpio_lvl_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk     (clk),
    .por_n   (por_n),
    .mrst_n  (mrst_n),
    .lvl_s   (lvl_s),
    .ien_q   (ien_q),
    .irq_req (irq_req)
  );

  assign pad_oe  = dir_q;
  assign pad_out = dat_q;

endmodule

// File: rtl/gpio_lvl_port_chk.sv
`timescale 1ns/1ps
module gpio_lvl_port_chk #(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned IRQ_W  = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              mrst_n,
  input logic              standby,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_oe,
  input logic              irq_req,
  input logic [IRQ_W-1:0]  ien_q
);

  logic [PORT_W-1:0] even_bits;
  logic              wr_go;

  always_comb begin
    for (int n = 0; n < PORT_W; n++) even_bits[n] = bus_wdata[2*n];
  end

  assign wr_go = bus_wr && mrst_n && !standby;

  p_oe_from_even_r1: assert property (@(posedge clk) disable iff (!por_n)
    (wr_go && bus_addr == 2'd0) |=> (pad_oe == $past(even_bits)));

  p_out_from_latch_r2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_go && bus_addr == 2'd1) |=> (pad_out == $past(bus_wdata[PORT_W-1:0])));

  p_data_upper_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rvalid && $past(bus_addr) == 2'd1) |-> (bus_rdata[REG_W-1:PORT_W] == '0));

  always @(posedge clk) begin
    if (!por_n) begin
      a_ien_cleared_r6: assert (ien_q == '0);
    end
  end

  p_irq_needs_release_r7: assert property (@(posedge clk) disable iff (!por_n)
    irq_req |-> $past(mrst_n));

  p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!por_n)
    ($past(ien_q) == '0) |-> !irq_req);

  p_mrst_quiet_r10: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n |=> (!irq_req && !bus_rvalid));

  p_standby_frozen_r11: assert property (@(posedge clk) disable iff (!por_n)
    (standby && mrst_n) |=> ($stable(ien_q) && $stable(pad_oe) && $stable(pad_out)));

  p_rvalid_pulse_r12: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && mrst_n) |=> bus_rvalid);

  p_rvalid_only_r12: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_rd && mrst_n) |=> !bus_rvalid);

  p_ien_old_value_r12: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rvalid && $past(bus_addr) == 2'd2) |-> (bus_rdata[IRQ_W-1:0] == $past(ien_q)));

endmodule

bind gpio_lvl_port gpio_lvl_port_chk #(
  .PORT_W(PORT_W), .REG_W(REG_W), .IRQ_W(IRQ_W)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .mrst_n     (mrst_n),
  .standby    (standby),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .irq_req    (irq_req),
  .ien_q      (ien_q)
);

// File: tb/gpio_lvl_port_bench.sv
`timescale 1ns/1ps
module gpio_lvl_port_bench;

  logic        clk = 1'b0;
  logic        por_n, mrst_n, standby;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  pad_in, pad_out, pad_oe;
  logic [15:0] gpin_n;
  logic        irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_lvl_port u_gpio_lvl_port (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .gpin_n(gpin_n), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic v;
    check("R1 oe after por", {12'b0, pad_oe}, 16'h0);
    check("R7 irq after por", {15'b0, irq_req}, 16'h0);
    rd(2'd2, d, v);
    check("R6 ien after por", d, 16'h0);
    check("R12 rvalid", {15'b0, v}, 16'h1);
    idle(1);
    check("R12 rvalid single", {15'b0, bus_rvalid}, 16'h0);
  endtask

  task automatic t_dir();
    logic [15:0] d; logic v;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d, v);
    check("R1 dir even only", d, 16'h0055);
    check("R1 oe all", {12'b0, pad_oe}, 16'h000F);
    wr(2'd0, 16'h0104);
    rd(2'd0, d, v);
    check("R1 dir bit2 only", d, 16'h0004);
    check("R1 oe bit1", {12'b0, pad_oe}, 16'h0002);
  endtask

  task automatic t_output();
    logic [15:0] d; logic v;
    wr(2'd0, 16'h0055);
    wr(2'd1, 16'h0009);
    pad_in = 4'h6;
    idle(3);
    rd(2'd1, d, v);
    check("R2 output readback", d, 16'h0009);
    check("R2 pad_out", {12'b0, pad_out}, 16'h0009);
  endtask

  task automatic t_input();
    logic [15:0] d; logic v;
    wr(2'd0, 16'h0000);
    idle(1);
    rd(2'd1, d, v);
    check("R3 input level", d, 16'h0006);
    pad_in = 4'hF;
    rd(2'd1, d, v);
    check("R3 too early", d, 16'h0006);
    rd(2'd1, d, v);
    check("R3 after two stages", d, 16'h000F);
    pad_in = 4'h6;
    wr(2'd0, 16'h0005);
    idle(3);
    rd(2'd1, d, v);
    check("R2 R3 mixed", d, 16'h0005);
  endtask

  task automatic t_upper();
    logic [15:0] d; logic v;
    wr(2'd0, 16'h0055);
    wr(2'd1, 16'hFFF3);
    rd(2'd1, d, v);
    check("R4 upper data bits", d, 16'h0003);
  endtask

  task automatic t_por_retention();
    logic [15:0] d; logic v;
    wr(2'd1, 16'h000C);
    wr(2'd2, 16'h00F0);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    idle(1);
    rd(2'd2, d, v);
    check("R6 ien cleared by por", d, 16'h0000);
    rd(2'd0, d, v);
    check("R1 dir cleared by por", d, 16'h0000);
    wr(2'd0, 16'h0055);
    rd(2'd1, d, v);
    check("R5 latch kept over por", d, 16'h000C);
    check("R5 pad_out kept", {12'b0, pad_out}, 16'h000C);
  endtask

  task automatic t_mrst();
    logic [15:0] d; logic v;
    wr(2'd2, 16'h0003);
    gpin_n = 16'hFFFE;
    idle(4);
    check("R7 irq before mrst", {15'b0, irq_req}, 16'h1);
    @(negedge clk); mrst_n = 1'b0;
    @(negedge clk);
    check("R10 irq low in mrst", {15'b0, irq_req}, 16'h0);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0001);
    rd(2'd2, d, v);
    check("R10 no response in mrst", {15'b0, v}, 16'h0);
    @(negedge clk); mrst_n = 1'b1;
    idle(2);
    check("R7 irq back after mrst", {15'b0, irq_req}, 16'h1);
    rd(2'd2, d, v);
    check("R6 ien kept over mrst", d, 16'h0003);
    rd(2'd1, d, v);
    check("R5 latch kept over mrst", d, 16'h000C);
    gpin_n = 16'hFFFF;
    idle(4);
  endtask

  task automatic t_irq_latency();
    wr(2'd2, 16'h8000);
    @(negedge clk); gpin_n = 16'h7FFF;
    @(negedge clk); check("R7 rise edge1", {15'b0, irq_req}, 16'h0);
    @(negedge clk); check("R7 rise edge2", {15'b0, irq_req}, 16'h0);
    @(negedge clk); check("R7 rise edge3", {15'b0, irq_req}, 16'h1);
    idle(6);
    check("R7 held while low", {15'b0, irq_req}, 16'h1);
    gpin_n = 16'hFFFF;
    @(negedge clk); check("R7 fall edge1", {15'b0, irq_req}, 16'h1);
    @(negedge clk); check("R7 fall edge2", {15'b0, irq_req}, 16'h1);
    @(negedge clk); check("R7 fall edge3", {15'b0, irq_req}, 16'h0);
  endtask

  task automatic t_mask();
    wr(2'd2, 16'h0001);
    gpin_n = 16'hFFDF;
    idle(6);
    check("R8 masked pin5", {15'b0, irq_req}, 16'h0);
    gpin_n = 16'hFFDE;
    idle(4);
    check("R8 enabled pin0", {15'b0, irq_req}, 16'h1);
    wr(2'd2, 16'h0000);
    gpin_n = 16'h0000;
    idle(6);
    check("R8 all masked all low", {15'b0, irq_req}, 16'h0);
    gpin_n = 16'hFFFF;
    idle(4);
  endtask

  task automatic t_pinlvl();
    logic [15:0] d; logic v;
    gpin_n = 16'h5A3C;
    idle(3);
    rd(2'd3, d, v);
    check("R9 pin levels", d, 16'h5A3C);
    wr(2'd3, 16'h0000);
    rd(2'd3, d, v);
    check("R9 write ignored", d, 16'h5A3C);
    gpin_n = 16'hFFFF;
    idle(4);
  endtask

  task automatic t_standby();
    logic [15:0] d; logic v;
    wr(2'd2, 16'h0002);
    @(negedge clk); standby = 1'b1;
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hFFFF);
    rd(2'd1, d, v);
    check("R11 latch frozen", d, 16'h000C);
    check("R11 read answered", {15'b0, v}, 16'h1);
    check("R11 oe frozen", {12'b0, pad_oe}, 16'h000F);
    rd(2'd2, d, v);
    check("R11 ien frozen", d, 16'h0002);
    gpin_n = 16'hFFFD;
    idle(4);
    check("R11 irq live in standby", {15'b0, irq_req}, 16'h1);
    gpin_n = 16'hFFFF;
    @(negedge clk); standby = 1'b0;
    idle(4);
  endtask

  task automatic t_collision();
    logic [15:0] d; logic v;
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h1230;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R12 read sees old", d, 16'h0002);
    check("R12 rvalid collide", {15'b0, v}, 16'h1);
    rd(2'd2, d, v);
    check("R12 next read new", d, 16'h1230);
    gpin_n = 16'hFFF7;
    idle(5);
    check("R8 pin3 not enabled", {15'b0, irq_req}, 16'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0008;
    @(negedge clk); bus_wr = 1'b0;
    check("R7 enable while low n+1", {15'b0, irq_req}, 16'h0);
    @(negedge clk);
    check("R7 enable while low n+2", {15'b0, irq_req}, 16'h1);
    gpin_n = 16'hFFFF;
    idle(4);
  endtask

  initial begin
    por_n = 1'b0; mrst_n = 1'b1; standby = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 16'h0;
    pad_in = 4'h0; gpin_n = 16'hFFFF;
    idle(3);
    por_n = 1'b1;
    idle(2);
    t_reset();
    t_dir();
    t_output();
    t_input();
    t_upper();
    t_por_retention();
    t_mrst();
    t_irq_latency();
    t_mask();
    t_pinlvl();
    t_standby();
    t_collision();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule